// File: doc/BRIEF.md
# Bus Fault Capture and Rerun Controller

This block sits beside a processor's bus interface and watches each access it issues. It flags an alignment fault when a word, a long word or an instruction fetch targets an odd address. It also takes an externally signalled bus error. On either fault it aborts the access in the same cycle and selects the exception vector. It then records the faulted cycle's context in a 16-bit status word and keeps the fault address alongside it.

The block tracks whether exception entry is in progress. A second fault during that window halts the processor for good, and so does a fault while the reset sequence is running. When the handler issues a return strobe, the block reads the rerun flag in the status word. A clear flag makes it request a hardware replay at the saved address. A set flag, which software writes after finishing the cycle itself, makes it skip the replay.

Top module: `bus_fault_ctrl`

## Requirements
- R1: With acc_valid_i high, address bit 0 set, and either acc_size_i of word (1) or long (2) or acc_ifetch_i high, abort_o rises in the same cycle and vec_o reads 2 (alignment).
- R2: A byte access (acc_size_i = 0, acc_ifetch_i low) at any address, or any access at an even address without bus_err_i, gives no abort and leaves status_o unchanged.
- R3: bus_err_i with acc_valid_i gives abort_o and vec_o = 1 (bus error) in the same cycle. When an alignment fault and a bus error coincide, vec_o reads 2.
- R4: One cycle after a captured fault, status_o holds the following fields:
  - bit 15 = 0 (rerun flag)
  - bit 13 = instruction fetch
  - bit 12 = data fetch
  - bit 11 = read-modify-write
  - bit 10 = high byte
  - bit 9 = 1 when the size is byte
  - bit 8 = 1 for a read
  - bits 2..0 = function code
  - all other bits = 0
- R5: fault_addr_o holds the faulted address from the cycle after capture. It and status_o hold their values until the next captured fault.
- R6: A fault while exception entry is pending (a capture and no exc_done_i since), or while rst_seq_i is high, raises halt_o one cycle later and does not overwrite status_o or fault_addr_o. halt_o stays high until reset, and while it is high abort_o stays low.
- R7: exc_done_i ends the pending exception, so the next fault is captured normally without halting.
- R8: A pulse on sw_wr_i writes sw_rerun_i into status bit 15, visible the next cycle.
- R9: rte_i with status bit 15 clear gives a one-cycle rerun_o pulse on the next cycle, with fault_addr_o as the replay address. A replay at an uncorrected odd address faults again.
- R10: rte_i with status bit 15 set gives a one-cycle skip_o pulse on the next cycle, and rerun_o stays low.
- R11: After reset, status_o, fault_addr_o, halt_o, rerun_o and skip_o are all zero, and no exception is pending.
- R12: While halt_o is high, rte_i produces neither rerun_o nor skip_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is issued this cycle |
| acc_addr_i | input | AW | Access address |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 long |
| acc_rd_i | input | 1 | 1 read, 0 write |
| acc_fc_i | input | 3 | Function code |
| acc_ifetch_i | input | 1 | Instruction fetch |
| acc_dfetch_i | input | 1 | Data fetch |
| acc_rmw_i | input | 1 | Read-modify-write cycle |
| acc_hb_i | input | 1 | High byte of the transfer register |
| bus_err_i | input | 1 | Bus error for the current access |
| rst_seq_i | input | 1 | Reset exception sequence under way |
| exc_done_i | input | 1 | Exception entry sequence finished |
| sw_wr_i | input | 1 | Software write strobe for the rerun flag |
| sw_rerun_i | input | 1 | Rerun flag value to write |
| rte_i | input | 1 | Return-from-exception strobe |
| abort_o | output | 1 | Abort current access |
| vec_o | output | 2 | 0 none, 1 bus error, 2 alignment |
| status_o | output | 16 | Fault status word |
| fault_addr_o | output | AW | Saved fault address, replay address |
| halt_o | output | 1 | Processor halted |
| rerun_o | output | 1 | Replay request pulse |
| skip_o | output | 1 | Replay skipped pulse |

## Verification
A pending flag that stays stuck high shows up on the next fault as an unexpected halt_o, one cycle after that fault. A pending flag that never sets shows up as a missing halt on a nested fault and as a status word overwritten by the second fault. A status field lost at capture appears on status_o one cycle after the abort. A rerun flag with the wrong value swaps rerun_o and skip_o in the cycle after the return strobe. A bad alignment decode is visible in the same cycle as the access, on abort_o and vec_o.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} acc_size_e;
  typedef enum logic [1:0] {VEC_NONE = 2'd0, VEC_BUS = 2'd1, VEC_ALIGN = 2'd2} vec_e;
  localparam int unsigned SW_W    = 16;
  localparam int unsigned RR_BIT  = 15;
  localparam int unsigned IF_BIT  = 13;
  localparam int unsigned DF_BIT  = 12;
  localparam int unsigned RM_BIT  = 11;
  localparam int unsigned HB_BIT  = 10;
  localparam int unsigned BY_BIT  = 9;
  localparam int unsigned RW_BIT  = 8;
  localparam int unsigned FC_W    = 3;
endpackage

// File: rtl/bfc_detect.sv
module bfc_detect
  import bfc_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          ifetch_i,
  input  logic          berr_i,
  output logic          fault_o,
  output logic [1:0]    vec_o
);
  logic wide, align_flt, bus_flt;

  assign wide      = (size_i != SZ_BYTE) || ifetch_i;
  assign align_flt = valid_i && addr_i[0] && wide;
  assign bus_flt   = valid_i && berr_i;
  assign fault_o   = align_flt || bus_flt;

  // alignment wins: detected before the bus cycle starts
  always_comb begin
    if (align_flt)    vec_o = VEC_ALIGN;
    else if (bus_flt) vec_o = VEC_BUS;
    else              vec_o = VEC_NONE;
  end
endmodule

// File: rtl/bfc_capture.sv
module bfc_capture
  import bfc_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      size_i,
  input  logic            rd_i,
  input  logic [FC_W-1:0] fc_i,
  input  logic            ifetch_i,
  input  logic            dfetch_i,
  input  logic            rmw_i,
  input  logic            hb_i,
  input  logic            sw_wr_i,
  input  logic            sw_rr_i,
  output logic [SW_W-1:0] status_o,
  output logic [AW-1:0]   addr_o
);
  logic [SW_W-1:0] word_n;

  always_comb begin
    word_n         = '0;
    word_n[IF_BIT] = ifetch_i;
    word_n[DF_BIT] = dfetch_i;
    word_n[RM_BIT] = rmw_i;
    word_n[HB_BIT] = hb_i;
    word_n[BY_BIT] = (size_i == SZ_BYTE);
    word_n[RW_BIT] = rd_i;
    word_n[FC_W-1:0] = fc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      addr_o   <= '0;
    end else if (cap_i) begin
      status_o <= word_n;
      addr_o   <= addr_i;
    end else if (sw_wr_i) begin
      status_o[RR_BIT] <= sw_rr_i;
    end
  end
endmodule

// File: rtl/bfc_seq.sv
module bfc_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic rst_seq_i,
  input  logic exc_done_i,
  input  logic rte_i,
  input  logic rr_i,
  output logic cap_o,
  output logic halt_o,
  output logic in_exc_o,
  output logic rerun_o,
  output logic skip_o
);
  logic nest;

  assign cap_o = fault_i && !halt_o && !in_exc_o && !rst_seq_i;
  assign nest  = fault_i && !halt_o && (in_exc_o || rst_seq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o   <= 1'b0;
      in_exc_o <= 1'b0;
      rerun_o  <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      if (nest)            halt_o   <= 1'b1;
      if (cap_o)           in_exc_o <= 1'b1;
      else if (exc_done_i) in_exc_o <= 1'b0;
      rerun_o <= rte_i && !halt_o && !rr_i;
      skip_o  <= rte_i && !halt_o && rr_i;
    end
  end
endmodule

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
  import bfc_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_size_i,
  input  logic          acc_rd_i,
  input  logic [2:0]    acc_fc_i,
  input  logic          acc_ifetch_i,
  input  logic          acc_dfetch_i,
  input  logic          acc_rmw_i,
  input  logic          acc_hb_i,
  input  logic          bus_err_i,
  input  logic          rst_seq_i,
  input  logic          exc_done_i,
  input  logic          sw_wr_i,
  input  logic          sw_rerun_i,
  input  logic          rte_i,
  output logic          abort_o,
  output logic [1:0]    vec_o,
  output logic [15:0]   status_o,
  output logic [AW-1:0] fault_addr_o,
  output logic          halt_o,
  output logic          rerun_o,
  output logic          skip_o
);
  logic       fault, cap, in_exc;
  logic [1:0] vec_raw;

  bfc_detect #(.AW(AW)) u_detect (
    .valid_i (acc_valid_i),
    .addr_i  (acc_addr_i),
    .size_i  (acc_size_i),
    .ifetch_i(acc_ifetch_i),
    .berr_i  (bus_err_i),
    .fault_o (fault),
    .vec_o   (vec_raw)
  );

  bfc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault),
    .rst_seq_i (rst_seq_i),
    .exc_done_i(exc_done_i),
    .rte_i     (rte_i),
    .rr_i      (status_o[RR_BIT]),
    .cap_o     (cap),
    .halt_o    (halt_o),
    .in_exc_o  (in_exc),
    .rerun_o   (rerun_o),
    .skip_o    (skip_o)
  );

  bfc_capture #(.AW(AW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .addr_i  (acc_addr_i),
    .size_i  (acc_size_i),
    .rd_i    (acc_rd_i),
    .fc_i    (acc_fc_i),
    .ifetch_i(acc_ifetch_i),
    .dfetch_i(acc_dfetch_i),
    .rmw_i   (acc_rmw_i),
    .hb_i    (acc_hb_i),
    .sw_wr_i (sw_wr_i),
    .sw_rr_i (sw_rerun_i),
    .status_o(status_o),
    .addr_o  (fault_addr_o)
  );

  assign abort_o = fault && !halt_o;
  assign vec_o   = halt_o ? VEC_NONE : vec_raw;
endmodule

// File: rtl/bus_fault_ctrl_chk.sv
module bus_fault_ctrl_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic [1:0]    acc_size_i,
  input logic          acc_ifetch_i,
  input logic          bus_err_i,
  input logic          rst_seq_i,
  input logic          rte_i,
  input logic          abort_o,
  input logic [1:0]    vec_o,
  input logic [15:0]   status_o,
  input logic [AW-1:0] fault_addr_o,
  input logic          halt_o,
  input logic          rerun_o,
  input logic          skip_o,
  input logic          in_exc
);
  // R1
  align_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_addr_i[0] && (acc_size_i != 2'd0 || acc_ifetch_i) && !halt_o)
      |-> (abort_o && vec_o == 2'd2));
  // R3
  berr_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && bus_err_i && !halt_o) |-> (abort_o && vec_o != 2'd0));
  // R4
  rr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !in_exc && !rst_seq_i) |=> (status_o[15] == 1'b0 && status_o[14] == 1'b0));
  // R5
  addr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !in_exc && !rst_seq_i) |=> (fault_addr_o == $past(acc_addr_i)));
  // R6
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R6
  nest_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && (in_exc || rst_seq_i)) |=> (halt_o && $stable(fault_addr_o)));
  // R9
  rerun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i && !halt_o && !status_o[15]) |=> rerun_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rerun_o && skip_o));
  // R12
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && $past(halt_o)) |-> (!abort_o && !rerun_o && !skip_o));
endmodule

bind bus_fault_ctrl bus_fault_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .acc_size_i  (acc_size_i),
  .acc_ifetch_i(acc_ifetch_i),
  .bus_err_i   (bus_err_i),
  .rst_seq_i   (rst_seq_i),
  .rte_i       (rte_i),
  .abort_o     (abort_o),
  .vec_o       (vec_o),
  .status_o    (status_o),
  .fault_addr_o(fault_addr_o),
  .halt_o      (halt_o),
  .rerun_o     (rerun_o),
  .skip_o      (skip_o),
  .in_exc      (in_exc)
);

// File: tb/bus_fault_ctrl_bench.sv
`timescale 1ns/1ps
module bus_fault_ctrl_bench;
  localparam int unsigned AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_rd = 0, acc_if = 0, acc_df = 0, acc_rmw = 0, acc_hb = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = '0;
  logic [2:0] acc_fc = '0;
  logic berr = 0, rst_seq = 0, exc_done = 0, sw_wr = 0, sw_rr = 0, rte = 0;
  logic abort, halt, rerun, skip;
  logic [1:0] vec;
  logic [15:0] status;
  logic [AW-1:0] faddr;

  int unsigned n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bus_fault_ctrl #(.AW(AW)) u_bus_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_size_i(acc_size), .acc_rd_i(acc_rd), .acc_fc_i(acc_fc), .acc_ifetch_i(acc_if),
    .acc_dfetch_i(acc_df), .acc_rmw_i(acc_rmw), .acc_hb_i(acc_hb), .bus_err_i(berr),
    .rst_seq_i(rst_seq), .exc_done_i(exc_done), .sw_wr_i(sw_wr), .sw_rerun_i(sw_rr),
    .rte_i(rte), .abort_o(abort), .vec_o(vec), .status_o(status), .fault_addr_o(faddr),
    .halt_o(halt), .rerun_o(rerun), .skip_o(skip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sw_exp(input logic [1:0] sz, input logic rd,
      input logic [2:0] fc, input logic fi, input logic fd, input logic rm, input logic hb);
    return {1'b0, 1'b0, fi, fd, rm, hb, (sz == 2'd0), rd, 5'b0, fc};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    #5;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive an access at a negedge; the abort and vector are sampled 1 ns later,
  // then the access is dropped at the next negedge
  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz, input logic rd,
      input logic [2:0] fc, input logic fi, input logic fd, input logic rm,
      input logic hb, input logic be, output logic ab, output logic [1:0] v);
    acc_valid = 1; acc_addr = a; acc_size = sz; acc_rd = rd; acc_fc = fc;
    acc_if = fi; acc_df = fd; acc_rmw = rm; acc_hb = hb; berr = be;
    #1;
    ab = abort; v = vec;
    @(negedge clk);
    acc_valid = 0; berr = 0;
  endtask

  task automatic end_exc();
    exc_done = 1;
    @(negedge clk);
    exc_done = 0;
  endtask

  task automatic t_reset();
    chk("R11 status", status, 0);
    chk("R11 addr", faddr, 0);
    chk("R11 halt", halt, 0);
    chk("R11 rerun/skip", {rerun, skip}, 0);
  endtask

  task automatic t_align();
    logic ab; logic [1:0] v;
    access(24'h001235, 2'd1, 1, 3'd5, 0, 1, 0, 0, 0, ab, v);
    chk("R1 word odd abort", {ab, v}, {1'b1, 2'd2});
    chk("R4 status word", status, sw_exp(2'd1, 1, 3'd5, 0, 1, 0, 0));
    chk("R5 fault addr", faddr, 24'h001235);
    end_exc();
    access(24'h004001, 2'd0, 0, 3'd6, 1, 0, 0, 0, 0, ab, v);
    chk("R1 ifetch odd", {ab, v}, {1'b1, 2'd2});
    chk("R4 ifetch word", status, sw_exp(2'd0, 0, 3'd6, 1, 0, 0, 0));
    end_exc();
    access(24'h000011, 2'd2, 0, 3'd1, 0, 1, 1, 0, 0, ab, v);
    chk("R1 long odd", {ab, v}, {1'b1, 2'd2});
    chk("R4 rmw word", status, sw_exp(2'd2, 0, 3'd1, 0, 1, 1, 0));
    end_exc();
  endtask

  task automatic t_no_fault();
    logic ab; logic [1:0] v; logic [15:0] keep;
    keep = status;
    access(24'h000777, 2'd0, 1, 3'd2, 0, 1, 0, 1, 0, ab, v);
    chk("R2 odd byte no abort", {ab, v}, 0);
    access(24'h000800, 2'd2, 1, 3'd2, 0, 1, 0, 0, 0, ab, v);
    chk("R2 even long no abort", {ab, v}, 0);
    chk("R2 status kept", status, keep);
  endtask

  task automatic t_berr();
    logic ab; logic [1:0] v;
    access(24'h00A002, 2'd0, 0, 3'd3, 0, 1, 0, 1, 1, ab, v);
    chk("R3 bus error vec", {ab, v}, {1'b1, 2'd1});
    chk("R4 byte hb write", status, sw_exp(2'd0, 0, 3'd3, 0, 1, 0, 1));
    chk("R5 berr addr", faddr, 24'h00A002);
    end_exc();
    access(24'h00A003, 2'd1, 1, 3'd1, 0, 1, 0, 0, 1, ab, v);
    chk("R3 both -> align", {ab, v}, {1'b1, 2'd2});
    end_exc();
  endtask

  task automatic t_rerun();
    logic ab; logic [1:0] v;
    access(24'h000101, 2'd1, 1, 3'd5, 0, 1, 0, 0, 0, ab, v);
    end_exc();
    rte = 1;
    @(negedge clk);
    rte = 0;
    chk("R9 rerun pulse", {rerun, skip}, 2'b10);
    chk("R9 replay addr", faddr, 24'h000101);
    @(negedge clk);
    chk("R9 pulse ends", rerun, 0);
    access(faddr, 2'd1, 1, 3'd5, 0, 1, 0, 0, 0, ab, v);
    chk("R9 replay faults again", {ab, v}, {1'b1, 2'd2});
    end_exc();
  endtask

  task automatic t_skip();
    sw_rr = 1; sw_wr = 1;
    @(negedge clk);
    sw_wr = 0;
    chk("R8 rr set", status[15], 1);
    rte = 1;
    @(negedge clk);
    rte = 0;
    chk("R10 skip pulse", {rerun, skip}, 2'b01);
    @(negedge clk);
    chk("R10 pulse ends", skip, 0);
    sw_rr = 0; sw_wr = 1;
    @(negedge clk);
    sw_wr = 0;
    chk("R8 rr cleared", status[15], 0);
  endtask

  task automatic t_nest();
    logic ab; logic [1:0] v;
    access(24'h000203, 2'd1, 1, 3'd1, 0, 1, 0, 0, 0, ab, v);
    chk("R7 no halt after exc_done", halt, 0);
    access(24'h000305, 2'd2, 0, 3'd2, 0, 1, 0, 0, 0, ab, v);
    chk("R6 nested abort", ab, 1);
    chk("R6 halted", halt, 1);
    chk("R6 addr kept", faddr, 24'h000203);
    chk("R6 status kept", status, sw_exp(2'd1, 1, 3'd1, 0, 1, 0, 0));
    end_exc();
    access(24'h000401, 2'd1, 1, 3'd1, 0, 1, 0, 0, 1, ab, v);
    chk("R6 halted no abort", {ab, v}, 0);
    chk("R6 halt sticky", halt, 1);
    rte = 1;
    @(negedge clk);
    rte = 0;
    chk("R12 rte ignored", {rerun, skip}, 0);
  endtask

  task automatic t_rst_seq();
    logic ab; logic [1:0] v;
    do_reset();
    chk("R11 halt cleared", halt, 0);
    rst_seq = 1;
    access(24'h000000, 2'd2, 1, 3'd6, 0, 1, 0, 0, 1, ab, v);
    rst_seq = 0;
    chk("R6 fault in reset seq abort", ab, 1);
    chk("R6 halt in reset seq", halt, 1);
    chk("R6 no capture", status, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_align();
    t_no_fault();
    t_berr();
    t_rerun();
    t_skip();
    t_nest();
    t_rst_seq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule